// File: doc/BRIEF.md
# Link Equalization Phase Controller

This block sequences the four-phase transmitter preset negotiation that a serial link runs before it may carry traffic at the third-generation rate or above. One instance sits in each port. A role input tells it whether it acts as the downstream port or the upstream port. The role decides which port sweeps its transmitter settings in each fine-tuning phase.

A start pulse opens phase 0. In phase 0 the per-lane preset request is captured and the rate switch is requested. Phase 1 repeats training until every lane's error count over a measurement window falls below a programmable limit. Phase 2 then lets the upstream port sweep its presets while the downstream port holds its own. Phase 3 swaps those roles and ends with a verification window that must show no errors on any lane. The measurement hardware supplies a window-done pulse and one error count per lane. Presets are plain codes. Each phase is guarded by a timeout. When a timeout expires, the controller reports failure and requests a fall back to the previous rate.

Top module: `link_eq_ctrl`

## Requirements
- R1: After reset, every lane's transmitter preset is RST_PRESET (default 4), and the preset is never larger than 10. Lane i occupies bits [4i+3:4i] of `tx_preset` and `req_preset`, and `err_cnt` lane i occupies bits [ERRW*i+ERRW-1:ERRW*i].
- R2: A captured request code from 11 to 15 leaves that lane's previous preset unchanged and sets bit i of `preset_rej`. An accepted start clears all reject bits.
- R3: A start pulse is accepted only while the block is idle, done or failed. An accepted start enters phase 0 with `eq_busy`=1 and `eq_phase`=0. A start pulse during phases 0 to 3 has no effect.
- R4: In phase 0, a cycle with `req_vld` captures the per-lane request codes into `tx_preset`. On the next cycle `rate_req`=1 and the phase is 1.
- R5: In phase 1, a window-done pulse in which every lane's count is below `p1_err_limit` moves the controller to phase 2. Any other window-done pulse leaves it in phase 1.
- R6: In phase 2, the upstream role transmits presets 0, 1, … 10 in turn, one per window-done pulse. After the eleventh window it sets each lane to the preset with the lowest count, and a tie goes to the lower preset. The downstream role keeps its presets. Both roles enter phase 3 after eleven windows.
- R7: Phase 3 runs the same sweep with the roles swapped. The downstream role resets its presets to 0 on entry. After the sweep, a window-done pulse with all counts zero sets `eq_done`=1 and `eq_busy`=0, with `rate_req` kept at 1. A nonzero window keeps it in phase 3.
- R8: If TIMEOUT cycles pass in one phase without advancing, `eq_fail`=1 and `eq_busy`=0. A failure in phases 1 to 3 also sets `fallback_req`=1 and clears `rate_req`. A failure in phase 0 leaves `fallback_req`=0.
- R9: `eq_done` and `eq_fail` are never both high. While busy, the phase only stays the same or steps up by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_dsp | input | 1 | 1 = downstream role, 0 = upstream role |
| eq_start | input | 1 | Start pulse |
| req_vld | input | 1 | Per-lane preset request valid (phase 0) |
| req_preset | input | 4*LANES | Per-lane requested preset codes |
| meas_done | input | 1 | Measurement window finished; err_cnt valid |
| err_cnt | input | ERRW*LANES | Per-lane error counts over the window |
| p1_err_limit | input | ERRW | Phase 1 exit limit (count must be below) |
| tx_preset | output | 4*LANES | Per-lane transmitter preset |
| preset_rej | output | LANES | Per-lane rejected-request flag |
| rate_req | output | 1 | Request to run at the new rate |
| fallback_req | output | 1 | Request to return to the previous rate |
| eq_phase | output | 2 | Current phase while busy, else 0 |
| eq_busy | output | 1 | Negotiation in progress |
| eq_done | output | 1 | Negotiation completed |
| eq_fail | output | 1 | Negotiation timed out |

## Verification
Both roles run a full negotiation, so the bench sees one port sweep and the other hold in each fine-tuning phase. The sweep error profiles are chosen to tell apart:
- a unique minimum from a tie, where the lower preset must win;
- a flat profile, where preset 0 must win;
- a minimum at the last preset.

The phase 1 and verification windows are tried just at the limit and below it. This separates the strict and non-strict comparisons. A mixed request with one out-of-range code shows that the rejected lane keeps its preset while its neighbours load theirs. Timeouts are provoked in phase 0 and in phase 1 to separate the two fallback outcomes, and the result is checked one cycle on each side of expiry.

// File: rtl/leq_pkg.sv
package leq_pkg;
  localparam int PRESET_W   = 4;
  localparam int PRESET_MAX = 10;
  localparam int SWEEP_LAST = PRESET_MAX;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PH0,
    ST_PH1,
    ST_PH2,
    ST_PH3,
    ST_VERIFY,
    ST_DONE,
    ST_FAIL
  } leq_state_e;
endpackage

// File: rtl/leq_lane_tune.sv
module leq_lane_tune
  import leq_pkg::*;
#(
  parameter int ERRW       = 16,
  parameter int RST_PRESET = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                cap_en_i,
  input  logic [PRESET_W-1:0] cap_code_i,
  input  logic                init_i,
  input  logic                upd_i,
  input  logic                first_i,
  input  logic                last_i,
  input  logic [PRESET_W-1:0] idx_i,
  input  logic [ERRW-1:0]     err_i,
  input  logic [ERRW-1:0]     limit_i,
  output logic [PRESET_W-1:0] tx_o,
  output logic                rej_o,
  output logic                ok_o,
  output logic                zero_o
);
  localparam logic [PRESET_W-1:0] RST_CODE = PRESET_W'(RST_PRESET);
  localparam logic [PRESET_W-1:0] MAX_CODE = PRESET_W'(PRESET_MAX);

  logic [PRESET_W-1:0] tx_q, tx_d;
  logic                tx_en;
  logic                rej_q, rej_d, rej_en;
  logic [PRESET_W-1:0] bidx_q, bidx_d;
  logic [ERRW-1:0]     berr_q, berr_d;
  logic                take, code_ok;

  // Running minimum: strict compare keeps the earlier (lower) preset on ties.
  always_comb begin
    code_ok = (cap_code_i <= MAX_CODE);
    take    = first_i || (err_i < berr_q);
    bidx_d  = take ? idx_i : bidx_q;
    berr_d  = take ? err_i : berr_q;
  end

  always_comb begin
    tx_d  = tx_q;
    tx_en = 1'b0;
    if (cap_en_i && code_ok) begin
      tx_d  = cap_code_i;
      tx_en = 1'b1;
    end else if (init_i) begin
      tx_d  = '0;
      tx_en = 1'b1;
    end else if (upd_i) begin
      tx_d  = last_i ? bidx_d : idx_i + 1'b1;
      tx_en = 1'b1;
    end
  end

  always_comb begin
    rej_d  = rej_q;
    rej_en = 1'b0;
    if (clr_i) begin
      rej_d  = 1'b0;
      rej_en = 1'b1;
    end else if (cap_en_i) begin
      rej_d  = !code_ok;
      rej_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= RST_CODE;
      rej_q  <= 1'b0;
      bidx_q <= '0;
      berr_q <= '0;
    end else begin
      if (tx_en)  tx_q  <= tx_d;
      if (rej_en) rej_q <= rej_d;
      if (upd_i) begin
        bidx_q <= bidx_d;
        berr_q <= berr_d;
      end
    end
  end

  assign tx_o   = tx_q;
  assign rej_o  = rej_q;
  assign ok_o   = (err_i < limit_i);
  assign zero_o = (err_i == '0);

  AST_TX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_o <= MAX_CODE); // R1
  AST_REJ_KEEPS_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en_i && (cap_code_i > MAX_CODE)) |=> ($stable(tx_o) && rej_o)); // R2
  AST_SWEEP_PICK_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && last_i) |=> (tx_o <= $past(idx_i))); // R6
endmodule

// File: rtl/leq_phase_timer.sv
module leq_phase_timer #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, at_lim;

  always_comb begin
    at_lim = (cnt_q == LIM);
    cnt_en = clr_i || (run_i && !at_lim);
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && at_lim;

  AST_TIMER_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && at_lim && !clr_i) |=> (cnt_q == LIM)); // R8
endmodule

// File: rtl/leq_phase_fsm.sv
module leq_phase_fsm
  import leq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                role_dsp_i,
  input  logic                start_i,
  input  logic                req_vld_i,
  input  logic                meas_i,
  input  logic                p1_ok_i,
  input  logic                all_zero_i,
  input  logic                expired_i,
  output logic                cap_en_o,
  output logic                clr_o,
  output logic                init_o,
  output logic                upd_o,
  output logic                first_o,
  output logic                last_o,
  output logic [PRESET_W-1:0] idx_o,
  output logic                tmr_clr_o,
  output logic                tmr_run_o,
  output logic [1:0]          phase_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o,
  output logic                rate_o,
  output logic                fb_o
);
  localparam logic [PRESET_W-1:0] IDX_LAST = PRESET_W'(SWEEP_LAST);

  leq_state_e          st_q, st_d;
  logic [PRESET_W-1:0] idx_q, idx_d;
  logic                idx_en;
  logic                rate_q, rate_d, fb_q, fb_d;
  logic                at_last;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    idx_en    = 1'b0;
    rate_d    = rate_q;
    fb_d      = fb_q;
    cap_en_o  = 1'b0;
    clr_o     = 1'b0;
    init_o    = 1'b0;
    upd_o     = 1'b0;
    tmr_clr_o = 1'b0;
    at_last   = (idx_q == IDX_LAST);
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) begin
          st_d      = ST_PH0;
          clr_o     = 1'b1;
          tmr_clr_o = 1'b1;
          rate_d    = 1'b0;
          fb_d      = 1'b0;
        end
      end
      ST_PH0: begin
        if (req_vld_i) begin
          cap_en_o  = 1'b1;
          rate_d    = 1'b1;
          st_d      = ST_PH1;
          tmr_clr_o = 1'b1;
        end else if (expired_i) begin
          st_d = ST_FAIL;
        end
      end
      ST_PH1: begin
        if (meas_i && p1_ok_i) begin
          st_d      = ST_PH2;
          idx_d     = '0;
          idx_en    = 1'b1;
          init_o    = !role_dsp_i;
          tmr_clr_o = 1'b1;
        end else if (expired_i) begin
          st_d   = ST_FAIL;
          fb_d   = 1'b1;
          rate_d = 1'b0;
        end
      end
      ST_PH2: begin
        if (meas_i) begin
          upd_o  = !role_dsp_i;
          idx_en = 1'b1;
          if (at_last) begin
            st_d      = ST_PH3;
            idx_d     = '0;
            init_o    = role_dsp_i;
            tmr_clr_o = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if (expired_i) begin
          st_d   = ST_FAIL;
          fb_d   = 1'b1;
          rate_d = 1'b0;
        end
      end
      ST_PH3: begin
        if (meas_i) begin
          upd_o  = role_dsp_i;
          idx_en = 1'b1;
          if (at_last) begin
            st_d  = ST_VERIFY;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if (expired_i) begin
          st_d   = ST_FAIL;
          fb_d   = 1'b1;
          rate_d = 1'b0;
        end
      end
      ST_VERIFY: begin
        if (meas_i && all_zero_i) begin
          st_d = ST_DONE;
        end else if (expired_i) begin
          st_d   = ST_FAIL;
          fb_d   = 1'b1;
          rate_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      rate_q <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      rate_q <= rate_d;
      fb_q   <= fb_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  always_comb begin
    busy_o = (st_q == ST_PH0) || (st_q == ST_PH1) || (st_q == ST_PH2) ||
             (st_q == ST_PH3) || (st_q == ST_VERIFY);
    unique case (st_q)
      ST_PH1:            phase_o = 2'd1;
      ST_PH2:            phase_o = 2'd2;
      ST_PH3, ST_VERIFY: phase_o = 2'd3;
      default:           phase_o = 2'd0;
    endcase
  end

  assign first_o   = (idx_q == '0);
  assign last_o    = at_last;
  assign idx_o     = idx_q;
  assign tmr_run_o = busy_o;
  assign done_o    = (st_q == ST_DONE);
  assign fail_o    = (st_q == ST_FAIL);
  assign rate_o    = rate_q;
  assign fb_o      = fb_q;

  AST_PHASE_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ((phase_o == $past(phase_o)) ||
                                   (phase_o == $past(phase_o) + 2'd1))); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !req_vld_i && !meas_i && !expired_i) |=>
      (phase_o == $past(phase_o)) && busy_o); // R3
  AST_CAPTURE_RAISES_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_PH0) && req_vld_i) |=> (rate_o && (phase_o == 2'd1))); // R4
  AST_P1_HOLDS_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_PH1) && meas_i && !p1_ok_i && !expired_i) |=> (phase_o == 2'd1)); // R5
endmodule

// File: rtl/link_eq_ctrl.sv
module link_eq_ctrl
  import leq_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int ERRW       = 16,
  parameter int TIMEOUT    = 1024,
  parameter int RST_PRESET = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      role_dsp,
  input  logic                      eq_start,
  input  logic                      req_vld,
  input  logic [PRESET_W*LANES-1:0] req_preset,
  input  logic                      meas_done,
  input  logic [ERRW*LANES-1:0]     err_cnt,
  input  logic [ERRW-1:0]           p1_err_limit,
  output logic [PRESET_W*LANES-1:0] tx_preset,
  output logic [LANES-1:0]          preset_rej,
  output logic                      rate_req,
  output logic                      fallback_req,
  output logic [1:0]                eq_phase,
  output logic                      eq_busy,
  output logic                      eq_done,
  output logic                      eq_fail
);
  logic                cap_en, clr, init, upd, first, last;
  logic [PRESET_W-1:0] idx;
  logic                tmr_clr, tmr_run, expired;
  logic [LANES-1:0]    lane_ok, lane_zero;

  leq_phase_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .role_dsp_i (role_dsp),
    .start_i    (eq_start),
    .req_vld_i  (req_vld),
    .meas_i     (meas_done),
    .p1_ok_i    (&lane_ok),
    .all_zero_i (&lane_zero),
    .expired_i  (expired),
    .cap_en_o   (cap_en),
    .clr_o      (clr),
    .init_o     (init),
    .upd_o      (upd),
    .first_o    (first),
    .last_o     (last),
    .idx_o      (idx),
    .tmr_clr_o  (tmr_clr),
    .tmr_run_o  (tmr_run),
    .phase_o    (eq_phase),
    .busy_o     (eq_busy),
    .done_o     (eq_done),
    .fail_o     (eq_fail),
    .rate_o     (rate_req),
    .fb_o       (fallback_req)
  );

  leq_phase_timer #(.TIMEOUT(TIMEOUT)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .run_i     (tmr_run),
    .expired_o (expired)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    leq_lane_tune #(.ERRW(ERRW), .RST_PRESET(RST_PRESET)) i_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .cap_en_i   (cap_en),
      .cap_code_i (req_preset[PRESET_W*g +: PRESET_W]),
      .init_i     (init),
      .upd_i      (upd),
      .first_i    (first),
      .last_i     (last),
      .idx_i      (idx),
      .err_i      (err_cnt[ERRW*g +: ERRW]),
      .limit_i    (p1_err_limit),
      .tx_o       (tx_preset[PRESET_W*g +: PRESET_W]),
      .rej_o      (preset_rej[g]),
      .ok_o       (lane_ok[g]),
      .zero_o     (lane_zero[g])
    );
  end

  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(eq_done && eq_fail)); // R9
  AST_DONE_KEEPS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    eq_done |-> (rate_req && !fallback_req && !eq_busy)); // R7
  AST_FAIL_DROPS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    eq_fail |-> (!rate_req && !eq_busy)); // R8
endmodule

// File: tb/test_link_eq_ctrl.sv
module test_link_eq_ctrl;
  localparam int LANES = 4;
  localparam int ERRW  = 16;
  localparam int TO    = 200;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 role_dsp = 1'b0;
  logic                 eq_start = 1'b0;
  logic                 req_vld = 1'b0;
  logic [4*LANES-1:0]   req_preset = '0;
  logic                 meas_done = 1'b0;
  logic [ERRW*LANES-1:0] err_cnt = '0;
  logic [ERRW-1:0]      p1_err_limit = 16'd10;
  logic [4*LANES-1:0]   tx_preset;
  logic [LANES-1:0]     preset_rej;
  logic                 rate_req, fallback_req, eq_busy, eq_done, eq_fail;
  logic [1:0]           eq_phase;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  link_eq_ctrl #(.LANES(LANES), .ERRW(ERRW), .TIMEOUT(TO), .RST_PRESET(4)) i_link_eq_ctrl (
    .clk(clk), .rst_n(rst_n), .role_dsp(role_dsp), .eq_start(eq_start),
    .req_vld(req_vld), .req_preset(req_preset), .meas_done(meas_done),
    .err_cnt(err_cnt), .p1_err_limit(p1_err_limit), .tx_preset(tx_preset),
    .preset_rej(preset_rej), .rate_req(rate_req), .fallback_req(fallback_req),
    .eq_phase(eq_phase), .eq_busy(eq_busy), .eq_done(eq_done), .eq_fail(eq_fail)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] pk(input int e0, input int e1, input int e2, input int e3);
    return {16'(e3), 16'(e2), 16'(e1), 16'(e0)};
  endfunction

  task automatic pulse_start();
    eq_start = 1'b1; tick(); eq_start = 1'b0;
  endtask

  task automatic capture(input logic [15:0] codes);
    req_preset = codes; req_vld = 1'b1; tick(); req_vld = 1'b0;
  endtask

  task automatic meas(input logic [63:0] e);
    err_cnt = e; meas_done = 1'b1; tick(); meas_done = 1'b0; tick();
  endtask

  task automatic t_reset();
    chk("R1 reset tx", tx_preset, 16'h4444);
    chk("R1 reset rej", preset_rej, 0);
    chk("R3 reset busy", eq_busy, 0);
    chk("R9 reset done/fail", {eq_done, eq_fail, rate_req}, 0);
  endtask

  task automatic t_upstream_run();
    role_dsp = 1'b0;
    pulse_start();
    chk("R3 start phase0", {eq_busy, eq_phase}, 3'b100);
    capture(16'hCA73);
    chk("R2 reject keeps lane3", tx_preset, 16'h4A73);
    chk("R2 reject flag", preset_rej, 4'b1000);
    chk("R4 rate and phase1", {rate_req, eq_phase}, 3'b101);
    pulse_start();
    chk("R3 start ignored busy", {eq_busy, eq_phase, preset_rej}, 7'b1011000);
    meas(pk(0, 0, 10, 0));
    chk("R5 at limit stays", eq_phase, 1);
    meas(pk(9, 9, 9, 9));
    chk("R5 below limit phase2", eq_phase, 2);
    chk("R6 upstream sweep start", tx_preset, 16'h0000);
    for (int k = 0; k < 11; k++) begin
      int d;
      d = (k > 5) ? k - 5 : 5 - k;
      meas(pk(3 * d + 1, (k == 2 || k == 7) ? 1 : 9, 20 - k, 6));
      if (k == 0) chk("R6 sweep step", tx_preset, 16'h1111);
    end
    chk("R6 best per lane", tx_preset, 16'h0A25);
    chk("R6 to phase3", eq_phase, 3);
    for (int k = 0; k < 11; k++) meas(pk(k, 1, 2, 3));
    chk("R7 upstream holds in phase3", tx_preset, 16'h0A25);
    meas(pk(0, 0, 1, 0));
    chk("R7 nonzero verify stays", {eq_done, eq_busy, eq_phase}, 4'b0111);
    meas(pk(0, 0, 0, 0));
    chk("R7 done", {eq_done, eq_busy, rate_req}, 3'b101);
    chk("R9 no fail on done", {eq_fail, fallback_req}, 0);
  endtask

  task automatic t_downstream_run();
    role_dsp = 1'b1;
    pulse_start();
    chk("R2 rej cleared on start", preset_rej, 0);
    chk("R3 restart from done", {eq_busy, eq_done, eq_phase}, 4'b1000);
    capture(16'h9999);
    chk("R4 capture", tx_preset, 16'h9999);
    meas(pk(1, 1, 1, 1));
    chk("R5 phase2", eq_phase, 2);
    for (int k = 0; k < 11; k++) begin
      meas(pk(k, 11 - k, 3, 5));
      if (k == 4) chk("R6 downstream holds", tx_preset, 16'h9999);
    end
    chk("R7 downstream sweep start", tx_preset, 16'h0000);
    chk("R6 downstream to phase3", eq_phase, 3);
    for (int k = 0; k < 11; k++)
      meas(pk((k == 10) ? 0 : 5, (k + 3) % 11, 4, (k == 3 || k == 9) ? 0 : 7));
    chk("R7 downstream best", tx_preset, 16'h308A);
    meas(pk(0, 0, 0, 0));
    chk("R7 downstream done", {eq_done, rate_req}, 2'b11);
  endtask

  task automatic t_timeout_p1();
    pulse_start();
    capture(16'h1111);
    repeat (TO - 2) tick();
    chk("R8 before expiry", {eq_fail, eq_busy}, 2'b01);
    repeat (3) tick();
    chk("R8 phase1 fail", {eq_fail, fallback_req, rate_req, eq_busy}, 4'b1100);
    chk("R9 fail not done", eq_done, 0);
  endtask

  task automatic t_timeout_p0();
    pulse_start();
    chk("R8 restart clears fallback", {fallback_req, eq_fail}, 0);
    repeat (TO + 2) tick();
    chk("R8 phase0 fail no fallback", {eq_fail, fallback_req, rate_req}, 3'b100);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_upstream_run();
    t_downstream_run();
    t_timeout_p1();
    t_timeout_p0();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule